// File: doc/BRIEF.md
# Serial Boot Handshake Command Parser

This block sits behind a UART receiver and watches the incoming ASCII byte stream for a boot handshake command. The command has four parts: a `>` prefix and a space, a fixed keyword (default `SYNC`), a separator character, and four hexadecimal fields. The separator selects the link mode: `*` requests single-wire operation and a space requests two-wire operation. The four fields form two mask/value pairs. These are tested against two local pin ports, so that several devices can share one host link and only the addressed device answers.

When a command matches, the block marks itself selected and stays silent for a turnaround time. This gives a half-duplex host time to release the line. It then sends a fixed version string and answers every later `?` with a `.`. A completed command that does not match deselects the device.

Bytes enter on a valid/ready stream. The transfer happens on any clock edge where both `rx_valid` and `rx_ready` are high. The block applies back-pressure only while a `.` reply is waiting to be accepted. Bytes leave on a valid/ready stream. Once `tx_valid` is raised it stays high with `tx_data` unchanged until the edge where `tx_ready` is high.

Top module: `boot_hs_parser`

## Requirements
- R1: After reset, `selected` and `single_wire` are 0, `tx_valid` is 0 and `rx_ready` is 1.
- R2: A command is `>` (0x3E), a space (0x20), the keyword `SYNC`, a separator, and four hex fields, with one space between fields. The command completes on the first non-hex byte after the fourth field.
- R3: Hex digits may be 0-9, A-F or a-f. A field holds 1 to 8 digits, most significant first. An empty field, or a ninth digit, abandons the command.
- R4: On completion, `selected` becomes 1 exactly when (pin_a & F1) == F2 and (pin_b & F3) == F4. The pins are sampled when the completing byte is accepted. A completed command that does not match sets `selected` to 0.
- R5: On every completed command, `single_wire` takes the value 1 if the separator was `*` (0x2A) and 0 if it was a space.
- R6: A byte that breaks the grammar abandons the command without completing it. If that byte is `>`, it starts a new command.
- R7: The first transmitted byte after a match becomes valid between TURN_CYC and TURN_CYC+2 cycles after the completing byte is accepted. Bytes received from completion until the version string has been sent are discarded.
- R8: After the turnaround, the block sends the version string `HSK-V2` followed by CR (0x0D) and LF (0x0A), in that order.
- R9: While selected and between commands, each received `?` (0x3F) produces exactly one `.` (0x2E). While not selected, nothing is transmitted.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value on the next cycle.
- R11: `rx_ready` is low only while a `.` reply is waiting to be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block accepts the received byte |
| rx_data | input | 8 | Received ASCII byte |
| pin_a | input | PIN_W | First local pin port, tested by fields 1 and 2 |
| pin_b | input | PIN_W | Second local pin port, tested by fields 3 and 4 |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Sink takes the transmit byte |
| tx_data | output | 8 | Transmit ASCII byte |
| single_wire | output | 1 | Link mode requested by the last completed command |
| selected | output | 1 | Last completed command addressed this device |

## Verification
The assertions take the following for granted. The sink eventually raises `tx_ready`. `TURN_CYC` is at least 1. Two commands never complete on back-to-back cycles, which holds because every command spans many bytes. The stimulus sends one byte per handshake and keeps the pin ports constant for the whole of each command. It also lowers `tx_ready` only at chosen points, so each stall can be observed and then released.

// File: rtl/bh_pkg.sv
package bh_pkg;
  localparam logic [7:0] CH_PROMPT = 8'h3E;
  localparam logic [7:0] CH_SP     = 8'h20;
  localparam logic [7:0] CH_STAR   = 8'h2A;
  localparam logic [7:0] CH_QRY    = 8'h3F;
  localparam logic [7:0] CH_DOT    = 8'h2E;

  typedef enum logic [1:0] {PH_OFF, PH_WAIT, PH_SEND, PH_ANS} phase_e;
  typedef enum logic [2:0] {PS_IDLE, PS_GAP, PS_KEY, PS_SEP, PS_HEX} pstate_e;

  function automatic logic is_hex(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46) ||
           (c >= 8'h61 && c <= 8'h66);
  endfunction

  function automatic logic [3:0] hex_nib(input logic [7:0] c);
    logic [7:0] t;
    if (c <= 8'h39)      t = c - 8'h30;
    else if (c <= 8'h46) t = c - 8'h37;
    else                 t = c - 8'h57;
    return t[3:0];
  endfunction
endpackage

// File: rtl/bh_cmd_parse.sv
module bh_cmd_parse
  import bh_pkg::*;
#(
  parameter int PIN_W = 32,
  parameter int KEY_LEN = 4,
  parameter logic [8*KEY_LEN-1:0] KEY_STR = "SYNC"
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic [PIN_W-1:0] pin_a,
  input  logic [PIN_W-1:0] pin_b,
  output logic             idle,
  output logic             done,
  output logic             match,
  output logic             flag
);
  localparam int DIG = PIN_W / 4;
  localparam int DW  = $clog2(DIG + 1);
  localparam int KW  = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

  logic [7:0] key_ch [KEY_LEN];
  for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
    assign key_ch[g] = KEY_STR[8*(KEY_LEN-1-g) +: 8];
  end

  pstate_e          st, bad_st;
  logic [KW-1:0]    kidx;
  logic [1:0]       fidx;
  logic [DW-1:0]    dcnt;
  logic [PIN_W-1:0] acc, msk_a, val_a, msk_b;

  assign bad_st = (in_byte == CH_PROMPT) ? PS_GAP : PS_IDLE;
  assign idle   = (st == PS_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= PS_IDLE;
      kidx  <= '0;
      fidx  <= '0;
      dcnt  <= '0;
      acc   <= '0;
      msk_a <= '0;
      val_a <= '0;
      msk_b <= '0;
      done  <= 1'b0;
      match <= 1'b0;
      flag  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (in_valid) begin
        unique case (st)
          PS_IDLE: if (in_byte == CH_PROMPT) st <= PS_GAP;
          PS_GAP: begin
            if (in_byte == CH_SP) begin
              st   <= PS_KEY;
              kidx <= '0;
            end else st <= bad_st;
          end
          PS_KEY: begin
            if (in_byte == key_ch[kidx]) begin
              if (kidx == KW'(KEY_LEN - 1)) st <= PS_SEP;
              else kidx <= kidx + 1'b1;
            end else st <= bad_st;
          end
          PS_SEP: begin
            if (in_byte == CH_SP || in_byte == CH_STAR) begin
              flag <= (in_byte == CH_STAR);
              st   <= PS_HEX;
              fidx <= '0;
              dcnt <= '0;
              acc  <= '0;
            end else st <= bad_st;
          end
          PS_HEX: begin
            if (is_hex(in_byte)) begin
              if (dcnt == DW'(DIG)) st <= bad_st;
              else begin
                acc  <= {acc[PIN_W-5:0], hex_nib(in_byte)};
                dcnt <= dcnt + 1'b1;
              end
            end else if (dcnt == '0) begin
              st <= bad_st;
            end else if (fidx == 2'd3) begin
              done  <= 1'b1;
              match <= ((pin_a & msk_a) == val_a) && ((pin_b & msk_b) == acc);
              st    <= PS_IDLE;
            end else if (in_byte == CH_SP) begin
              case (fidx)
                2'd0:    msk_a <= acc;
                2'd1:    val_a <= acc;
                default: msk_b <= acc;
              endcase
              fidx <= fidx + 1'b1;
              dcnt <= '0;
              acc  <= '0;
            end else st <= bad_st;
          end
          default: st <= PS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bh_turn_timer.sv
module bh_turn_timer #(
  parameter int TURN_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CW = $clog2(TURN_CYC + 1);

  logic [CW-1:0] cnt;
  logic          busy;

  assign expire = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= CW'(TURN_CYC);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == CW'(1)) busy <= 1'b0;
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/bh_ver_rom.sv
module bh_ver_rom #(
  parameter int VER_LEN = 8,
  parameter logic [8*VER_LEN-1:0] VER_STR = {"HSK-V2", 8'h0D, 8'h0A},
  localparam int IW = (VER_LEN > 1) ? $clog2(VER_LEN) : 1
) (
  input  logic [IW-1:0] idx,
  output logic [7:0]    ch
);
  logic [7:0] chars [VER_LEN];
  for (genvar g = 0; g < VER_LEN; g++) begin : g_ch
    assign chars[g] = VER_STR[8*(VER_LEN-1-g) +: 8];
  end
  assign ch = chars[idx];
endmodule

// File: rtl/boot_hs_parser.sv
module boot_hs_parser
  import bh_pkg::*;
#(
  parameter int PIN_W = 32,
  parameter int KEY_LEN = 4,
  parameter logic [8*KEY_LEN-1:0] KEY_STR = "SYNC",
  parameter int VER_LEN = 8,
  parameter logic [8*VER_LEN-1:0] VER_STR = {"HSK-V2", 8'h0D, 8'h0A},
  parameter int TURN_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic [PIN_W-1:0] pin_a,
  input  logic [PIN_W-1:0] pin_b,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             single_wire,
  output logic             selected
);
  localparam int IW = (VER_LEN > 1) ? $clog2(VER_LEN) : 1;

  phase_e        phase;
  logic [IW-1:0] vidx;
  logic          dot_pend;
  logic          cmd_done, cmd_match, cmd_flag, p_idle, t_expire;
  logic [7:0]    rom_ch;
  logic          rx_fire, tx_fire, is_query, feed;

  assign rx_ready = !((phase == PH_ANS) && dot_pend);
  assign rx_fire  = rx_valid && rx_ready;
  assign is_query = (rx_data == CH_QRY) && p_idle && (phase == PH_ANS);
  assign feed     = rx_fire && ((phase == PH_OFF) || (phase == PH_ANS)) && !is_query;
  assign tx_valid = (phase == PH_SEND) || ((phase == PH_ANS) && dot_pend);
  assign tx_data  = (phase == PH_SEND) ? rom_ch : CH_DOT;
  assign tx_fire  = tx_valid && tx_ready;

  bh_cmd_parse #(.PIN_W(PIN_W), .KEY_LEN(KEY_LEN), .KEY_STR(KEY_STR)) u_parse (
    .clk(clk), .rst_n(rst_n), .in_valid(feed), .in_byte(rx_data),
    .pin_a(pin_a), .pin_b(pin_b), .idle(p_idle), .done(cmd_done),
    .match(cmd_match), .flag(cmd_flag)
  );

  bh_turn_timer #(.TURN_CYC(TURN_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cmd_done && cmd_match), .expire(t_expire)
  );

  bh_ver_rom #(.VER_LEN(VER_LEN), .VER_STR(VER_STR)) u_rom (
    .idx(vidx), .ch(rom_ch)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_OFF;
      vidx        <= '0;
      dot_pend    <= 1'b0;
      selected    <= 1'b0;
      single_wire <= 1'b0;
    end else if (cmd_done) begin
      selected    <= cmd_match;
      single_wire <= cmd_flag;
      dot_pend    <= 1'b0;
      vidx        <= '0;
      phase       <= cmd_match ? PH_WAIT : PH_OFF;
    end else begin
      unique case (phase)
        PH_WAIT: if (t_expire) phase <= PH_SEND;
        PH_SEND: begin
          if (tx_fire) begin
            if (vidx == IW'(VER_LEN - 1)) phase <= PH_ANS;
            else vidx <= vidx + 1'b1;
          end
        end
        PH_ANS: begin
          if (dot_pend) begin
            if (tx_ready) dot_pend <= 1'b0;
          end else if (rx_fire && is_query) begin
            dot_pend <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/boot_hs_parser_chk.sv
module boot_hs_parser_chk #(
  parameter int TURN_CYC = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       selected,
  input logic       cmd_done,
  input logic       cmd_match
);
  logic        quiet;
  logic [31:0] qcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet <= 1'b0;
      qcnt  <= '0;
    end else if (cmd_done && cmd_match) begin
      quiet <= 1'b1;
      qcnt  <= '0;
    end else if (quiet) begin
      qcnt <= qcnt + 1'b1;
      if (tx_valid) quiet <= 1'b0;
    end
  end

  assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && tx_valid) |-> (qcnt >= 32'(TURN_CYC)));

  assert_tx_only_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> selected);

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_rx_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> (selected && tx_valid));
endmodule

bind boot_hs_parser boot_hs_parser_chk #(.TURN_CYC(TURN_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .selected(selected),
  .cmd_done(cmd_done), .cmd_match(cmd_match)
);

// File: tb/test_boot_hs_parser.sv
`timescale 1ns/1ps
module test_boot_hs_parser;
  localparam int TURN = 40;
  localparam int VLEN = 8;
  localparam logic [8*VLEN-1:0] VER_EXP = {"HSK-V2", 8'h0D, 8'h0A};

  typedef struct packed {
    logic        star;
    logic        lower;
    logic [31:0] pa, pb, m0, v0, m1, v1;
    logic        sel;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h12345678, 32'h9,        32'h0,        32'h0,        32'h0,        32'h0,        1'b1},
    '{1'b1, 1'b1, 32'h0001235A, 32'h0,        32'hFF,       32'h5A,       32'h0,        32'h0,        1'b1},
    '{1'b0, 1'b0, 32'h45,       32'h0,        32'hF0,       32'h30,       32'h0,        32'h0,        1'b0},
    '{1'b0, 1'b1, 32'h0,        32'hDEADBEEF, 32'h0,        32'h0,        32'hFFFFFFFF, 32'hDEADBEEF, 1'b1},
    '{1'b1, 1'b0, 32'h0,        32'h2,        32'h0,        32'h0,        32'h1,        32'h1,        1'b0},
    '{1'b1, 1'b0, 32'h80000001, 32'h6,        32'h80000000, 32'h80000000, 32'h3,        32'h2,        1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_ready, tx_valid, tx_ready, single_wire, selected;
  logic [7:0]  rx_data, tx_data;
  logic [31:0] pin_a, pin_b;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  boot_hs_parser #(.TURN_CYC(TURN)) i_boot_hs_parser (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .pin_a(pin_a), .pin_b(pin_b), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .single_wire(single_wire),
    .selected(selected)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input string what,
                           input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_data  = b;
    rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_byte(s[i]);
  endtask

  task automatic send_hex(input logic [31:0] v, input logic lower);
    int nd = 1;
    for (int i = 7; i > 0; i--) begin
      if (v[4*i +: 4] != 4'h0) begin
        nd = i + 1;
        break;
      end
    end
    for (int i = nd - 1; i >= 0; i--) begin
      logic [7:0] nib;
      nib = {4'h0, v[4*i +: 4]};
      send_byte(nib < 8'd10 ? 8'h30 + nib : (lower ? 8'h57 : 8'h37) + nib);
    end
  endtask

  task automatic send_cmd(input logic star, input logic lower, input logic [31:0] m0,
                          input logic [31:0] v0, input logic [31:0] m1, input logic [31:0] v1);
    send_str("> SYNC");
    send_byte(star ? 8'h2A : 8'h20);
    send_hex(m0, lower); send_byte(8'h20);
    send_hex(v0, lower); send_byte(8'h20);
    send_hex(m1, lower); send_byte(8'h20);
    send_hex(v1, lower); send_byte(8'h20);
  endtask

  task automatic get_tx(output logic [7:0] b);
    while (!tx_valid) @(negedge clk);
    b = tx_data;
    @(negedge clk);
  endtask

  task automatic expect_version(input string req);
    logic [7:0] b;
    for (int i = 0; i < VLEN; i++) begin
      get_tx(b);
      chk(req, "version byte", {24'h0, b}, {24'h0, VER_EXP[8*(VLEN-1-i) +: 8]});
    end
  endtask

  task automatic quiet_tx(input string req, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (tx_valid) seen = 1'b1;
      @(negedge clk);
    end
    chk(req, "no transmit", {31'h0, seen}, 32'h0);
  endtask

  task automatic wait_latency(output int lat);
    lat = 0;
    while (!tx_valid && lat < 1000) begin
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    int lat;
    rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; tx_ready = 1'b1;
    pin_a = '0; pin_b = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1", "selected after reset", {31'h0, selected}, 32'h0);
    chk("R1", "single_wire after reset", {31'h0, single_wire}, 32'h0);
    chk("R1", "tx_valid after reset", {31'h0, tx_valid}, 32'h0);
    chk("R1", "rx_ready after reset", {31'h0, rx_ready}, 32'h1);

    // R9: a query before any handshake gets no answer
    send_byte(8'h3F);
    quiet_tx("R9", 20);

    // R2 R4 R5: table of commands walked by one loop
    for (int v = 0; v < NV; v++) begin
      pin_a = VECS[v].pa;
      pin_b = VECS[v].pb;
      send_cmd(VECS[v].star, VECS[v].lower, VECS[v].m0, VECS[v].v0, VECS[v].m1, VECS[v].v1);
      if (VECS[v].sel) begin
        wait_latency(lat);
        chk_range("R7", "turnaround cycles", lat, TURN, TURN + 2);
        expect_version("R8");
        chk("R4", "selected on match", {31'h0, selected}, 32'h1);
        chk("R5", "single_wire flag", {31'h0, single_wire}, {31'h0, VECS[v].star});
        send_byte(8'h3F);
        get_tx(b);
        chk("R9", "query reply", {24'h0, b}, 32'h2E);
      end else begin
        repeat (2) @(negedge clk);
        chk("R4", "deselected on mismatch", {31'h0, selected}, 32'h0);
        chk("R5", "single_wire flag", {31'h0, single_wire}, {31'h0, VECS[v].star});
        send_byte(8'h3F);
        quiet_tx("R9", 20);
      end
    end

    // R6: broken keyword abandons, then '>' mid-command restarts
    pin_a = 32'h0; pin_b = 32'h0;
    send_cmd(1'b0, 1'b0, 32'h1, 32'h1, 32'h0, 32'h0);
    repeat (2) @(negedge clk);
    chk("R6", "deselect before test", {31'h0, selected}, 32'h0);
    send_str("> SYNX 0 0 0 0 ");
    repeat (2) @(negedge clk);
    chk("R6", "bad keyword not accepted", {31'h0, selected}, 32'h0);
    quiet_tx("R6", 10);
    send_str("> SY> SYNC*0 0 0 0 ");
    wait_latency(lat);
    expect_version("R6");
    chk("R6", "restart accepted", {31'h0, selected}, 32'h1);
    chk("R5", "star sets single_wire", {31'h0, single_wire}, 32'h1);

    // R3: nine-digit field and empty field abandon the command
    send_cmd(1'b0, 1'b0, 32'h1, 32'h1, 32'h0, 32'h0);
    repeat (2) @(negedge clk);
    send_str("> SYNC 000000000 0 0 0 ");
    repeat (2) @(negedge clk);
    chk("R3", "nine digits rejected", {31'h0, selected}, 32'h0);
    send_str("> SYNC  0 0 0 0 ");
    repeat (2) @(negedge clk);
    chk("R3", "empty field rejected", {31'h0, selected}, 32'h0);
    quiet_tx("R3", 10);
    send_str("> SYNC 00000000 0 aB 0 ");
    wait_latency(lat);
    expect_version("R3");
    chk("R3", "eight digits accepted", {31'h0, selected}, 32'h1);
    chk("R5", "space clears single_wire", {31'h0, single_wire}, 32'h0);

    // R7: queries during the turnaround are discarded
    send_cmd(1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
    send_byte(8'h3F);
    send_byte(8'h3F);
    wait_latency(lat);
    expect_version("R7");
    quiet_tx("R7", 20);

    // R10: stalled sink keeps the first version byte steady
    tx_ready = 1'b0;
    send_cmd(1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0);
    repeat (TURN + 10) @(negedge clk);
    chk("R10", "valid while stalled", {31'h0, tx_valid}, 32'h1);
    b = tx_data;
    repeat (5) @(negedge clk);
    chk("R10", "valid held", {31'h0, tx_valid}, 32'h1);
    chk("R10", "data held", {24'h0, tx_data}, {24'h0, b});
    tx_ready = 1'b1;
    expect_version("R10");

    // R11: a pending reply blocks the receive side
    tx_ready = 1'b0;
    rx_data = 8'h3F;
    rx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R11", "rx_ready low while reply pending", {31'h0, rx_ready}, 32'h0);
    chk("R9", "reply offered", {24'h0, tx_data}, 32'h2E);
    tx_ready = 1'b1;
    get_tx(b);
    chk("R11", "rx_ready back high", {31'h0, rx_ready}, 32'h1);
    quiet_tx("R9", 10);

    finish_run();
  end
endmodule